// File: doc/BRIEF.md
# Endpoint Interrupt Propagation Controller

This block gathers up to sixteen level-sensitive interrupt request lines from the local memory-mapped fabric and forwards them toward a PCI Express transaction layer. Depending on two bits taken from the configuration command register, it signals either through a message-signaled interrupt request strobe or through a legacy INTx assert/deassert request with an acknowledge handshake. When message signaling is off and the legacy interrupt disable bit is set, nothing is forwarded.

A small 32-bit register slave lets software read the live request lines and set a per-source enable mask. It also holds a bank of event status bits. Each event bit is set by a pulse on an event input and cleared by writing one to it. Each event bit has its own enable, and the enabled event bits are ORed into one interrupt output. Reads return data one cycle after the read strobe. The source lines are registered once before any use.

Top module: `irq_prop_ctrl`

## Requirements
- R1: After reset every register reads zero and msi_req_o, intx_req_o, intx_assert_o and csr_irq_o are 0.
- R2: A read of offset 0x00 returns the request lines in bits [15:0], as sampled on the previous clock, with zero above them. Read data appears on csr_rdata_o on the clock after the read strobe. A write to 0x00 has no effect.
- R3: Offset 0x04 is a read/write source enable mask in bits [15:0]. Upper write bits are dropped. A source whose enable bit is 0 causes no request of any kind.
- R4: With msi_en_i = 1, a 0-to-1 change of any enabled source raises msi_req_o for exactly one cycle. This happens on the second clock edge after the input change. No legacy request is made in this mode.
- R5: In legacy mode (msi_en_i = 0, intx_dis_i = 0), a 0-to-1 change of the OR of enabled sources raises intx_req_o with intx_assert_o = 1 (assert) on the second edge. The request and its polarity hold until intx_ack_i is sampled high, and intx_req_o drops on that edge.
- R6: In legacy mode, a 1-to-0 change of that OR issues a request with intx_assert_o = 0 (deassert), with the same timing and handshake as R5.
- R7: A new legacy request waits for the acknowledge of the previous one. It is issued on the edge after the acknowledged edge.
- R8: With msi_en_i = 0 and intx_dis_i = 1, neither msi_req_o nor an INTx assert request is raised.
- R9: Offset 0x08 holds the event status bits in bits [N_EVT-1:0]. A high evt_i bit sets its bit, and writing 1 clears it. If a set and a clear of the same bit occur in one cycle, the set wins.
- R10: Offset 0x0C is the event enable mask. csr_irq_o is 1 whenever any status bit and its enable bit are both 1.
- R11: A write to any other offset changes no register, and a read of any other offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| csr_addr_i | input | ADDR_W | Register byte offset |
| csr_wr_i | input | 1 | Write strobe |
| csr_rd_i | input | 1 | Read strobe |
| csr_wdata_i | input | 32 | Write data |
| csr_rdata_o | output | 32 | Read data, valid the cycle after csr_rd_i |
| irq_src_i | input | N_SRC | Interrupt request lines from the fabric |
| evt_i | input | N_EVT | Event pulses that set status bits |
| msi_en_i | input | 1 | MSI enable from configuration |
| intx_dis_i | input | 1 | Legacy interrupt disable from configuration |
| msi_req_o | output | 1 | One-cycle message interrupt request |
| intx_req_o | output | 1 | Legacy request, held until acknowledged |
| intx_assert_o | output | 1 | 1 = assert message, 0 = deassert message |
| intx_ack_i | input | 1 | Acknowledge of the legacy request |
| csr_irq_o | output | 1 | OR of enabled event status bits |

## Verification
The source lines pass one register and the request outputs pass a second. An MSI strobe or a legacy request is therefore due on the second rising edge after a source change. The bench changes inputs on falling edges and samples exactly two falling edges later. It also samples one edge beyond that to confirm that a strobe lasts a single cycle. Register reads take one edge, so each read task samples on the next falling edge. The combined event output follows a register write or event pulse after one edge. Handshake checks drive the acknowledge for one edge, then confirm that the request drops on that edge and that any queued request appears on the following one.

// File: rtl/irq_prop_pkg.sv
package irq_prop_pkg;
  localparam int unsigned DATA_W = 32;
  localparam logic [7:0] OFF_PEND    = 8'h00;
  localparam logic [7:0] OFF_SRC_EN  = 8'h04;
  localparam logic [7:0] OFF_EVT_STS = 8'h08;
  localparam logic [7:0] OFF_EVT_EN  = 8'h0C;
endpackage

// File: rtl/irq_prop_csr.sv
module irq_prop_csr
  import irq_prop_pkg::*;
#(
  parameter int unsigned N_SRC  = 16,
  parameter int unsigned N_EVT  = 4,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_SRC-1:0]  pend_i,
  input  logic [N_EVT-1:0]  evt_i,
  output logic [N_SRC-1:0]  src_en_o,
  output logic              evt_irq_o
);
  localparam int unsigned OFF_W = (ADDR_W < 8) ? ADDR_W : 8;

  logic hit_pend, hit_src_en, hit_evt_sts, hit_evt_en;
  logic [N_SRC-1:0] src_en_q;
  logic [N_EVT-1:0] evt_sts_q, evt_en_q;
  logic [DATA_W-1:0] rdata_d, rdata_q;

  assign hit_pend    = ({{(8-OFF_W){1'b0}}, addr_i[OFF_W-1:0]} == OFF_PEND)    && (ADDR_W <= 8 || addr_i[ADDR_W-1:OFF_W] == '0);
  assign hit_src_en  = ({{(8-OFF_W){1'b0}}, addr_i[OFF_W-1:0]} == OFF_SRC_EN)  && (ADDR_W <= 8 || addr_i[ADDR_W-1:OFF_W] == '0);
  assign hit_evt_sts = ({{(8-OFF_W){1'b0}}, addr_i[OFF_W-1:0]} == OFF_EVT_STS) && (ADDR_W <= 8 || addr_i[ADDR_W-1:OFF_W] == '0);
  assign hit_evt_en  = ({{(8-OFF_W){1'b0}}, addr_i[OFF_W-1:0]} == OFF_EVT_EN)  && (ADDR_W <= 8 || addr_i[ADDR_W-1:OFF_W] == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_en_q <= '0;
      evt_en_q <= '0;
    end else if (wr_i) begin
      if (hit_src_en) src_en_q <= wdata_i[N_SRC-1:0];
      if (hit_evt_en) evt_en_q <= wdata_i[N_EVT-1:0];
    end
  end

  // set has priority over write-one-to-clear
  for (genvar g = 0; g < N_EVT; g++) begin : g_evt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              evt_sts_q[g] <= 1'b0;
      else if (evt_i[g])                        evt_sts_q[g] <= 1'b1;
      else if (wr_i && hit_evt_sts && wdata_i[g]) evt_sts_q[g] <= 1'b0;
    end
  end

  always_comb begin
    rdata_d = '0;
    if (hit_pend)    rdata_d[N_SRC-1:0] = pend_i;
    if (hit_src_en)  rdata_d[N_SRC-1:0] = src_en_q;
    if (hit_evt_sts) rdata_d[N_EVT-1:0] = evt_sts_q;
    if (hit_evt_en)  rdata_d[N_EVT-1:0] = evt_en_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rdata_d;
  end

  assign rdata_o   = rdata_q;
  assign src_en_o  = src_en_q;
  assign evt_irq_o = |(evt_sts_q & evt_en_q);
endmodule

// File: rtl/irq_prop_msi.sv
module irq_prop_msi #(
  parameter int unsigned N_SRC = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] act_i,
  input  logic             msi_en_i,
  output logic             msi_req_o
);
  logic [N_SRC-1:0] prev_q;
  logic req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      req_q  <= 1'b0;
    end else begin
      prev_q <= act_i;
      req_q  <= msi_en_i && |(act_i & ~prev_q);
    end
  end

  assign msi_req_o = req_q;
endmodule

// File: rtl/irq_prop_intx.sv
module irq_prop_intx (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic want_i,
  input  logic ack_i,
  output logic req_o,
  output logic assert_o
);
  logic busy_q, line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      line_q <= 1'b0;
    end else if (busy_q) begin
      if (ack_i) busy_q <= 1'b0;
    end else if (want_i != line_q) begin
      busy_q <= 1'b1;
      line_q <= want_i;
    end
  end

  assign req_o    = busy_q;
  assign assert_o = line_q;
endmodule

// File: rtl/irq_prop_ctrl.sv
module irq_prop_ctrl
  import irq_prop_pkg::*;
#(
  parameter int unsigned N_SRC  = 16,
  parameter int unsigned N_EVT  = 4,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] csr_addr_i,
  input  logic              csr_wr_i,
  input  logic              csr_rd_i,
  input  logic [31:0]       csr_wdata_i,
  output logic [31:0]       csr_rdata_o,
  input  logic [N_SRC-1:0]  irq_src_i,
  input  logic [N_EVT-1:0]  evt_i,
  input  logic              msi_en_i,
  input  logic              intx_dis_i,
  output logic              msi_req_o,
  output logic              intx_req_o,
  output logic              intx_assert_o,
  input  logic              intx_ack_i,
  output logic              csr_irq_o
);
  logic [N_SRC-1:0] src_q, src_en, act;
  logic want;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= '0;
    else         src_q <= irq_src_i;
  end

  assign act  = src_q & src_en;
  assign want = |act && !msi_en_i && !intx_dis_i;

  irq_prop_csr #(.N_SRC(N_SRC), .N_EVT(N_EVT), .ADDR_W(ADDR_W)) u_csr (
    .clk_i, .rst_ni,
    .addr_i(csr_addr_i), .wr_i(csr_wr_i), .rd_i(csr_rd_i),
    .wdata_i(csr_wdata_i), .rdata_o(csr_rdata_o),
    .pend_i(src_q), .evt_i(evt_i),
    .src_en_o(src_en), .evt_irq_o(csr_irq_o)
  );

  irq_prop_msi #(.N_SRC(N_SRC)) u_msi (
    .clk_i, .rst_ni, .act_i(act), .msi_en_i(msi_en_i), .msi_req_o(msi_req_o)
  );

  irq_prop_intx u_intx (
    .clk_i, .rst_ni, .want_i(want), .ack_i(intx_ack_i),
    .req_o(intx_req_o), .assert_o(intx_assert_o)
  );
endmodule

// File: rtl/irq_prop_ctrl_chk.sv
module irq_prop_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic msi_en_i,
  input logic intx_dis_i,
  input logic msi_req_o,
  input logic intx_req_o,
  input logic intx_assert_o,
  input logic intx_ack_i
);
  AST_MSI_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msi_req_o |-> $past(msi_en_i)); // R4

  AST_INTX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intx_req_o && !intx_ack_i |=> intx_req_o && $stable(intx_assert_o)); // R5

  AST_ACK_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intx_req_o && intx_ack_i |=> !intx_req_o); // R7

  AST_DIS_NO_ASSERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(intx_req_o) && intx_assert_o |-> $past(!intx_dis_i && !msi_en_i)); // R8
endmodule

bind irq_prop_ctrl irq_prop_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .msi_en_i(msi_en_i), .intx_dis_i(intx_dis_i),
  .msi_req_o(msi_req_o), .intx_req_o(intx_req_o), .intx_assert_o(intx_assert_o),
  .intx_ack_i(intx_ack_i)
);

// File: tb/irq_prop_ctrl_test.sv
`timescale 1ns/1ps
module irq_prop_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] src = '0;
  logic [3:0]  evt = '0;
  logic        msi_en = 1'b0, intx_dis = 1'b0, ack = 1'b0;
  logic        msi_req, intx_req, intx_assert, csr_irq;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  irq_prop_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .csr_addr_i(addr), .csr_wr_i(wr), .csr_rd_i(rd),
    .csr_wdata_i(wdata), .csr_rdata_o(rdata), .irq_src_i(src), .evt_i(evt),
    .msi_en_i(msi_en), .intx_dis_i(intx_dis), .msi_req_o(msi_req),
    .intx_req_o(intx_req), .intx_assert_o(intx_assert), .intx_ack_i(ack),
    .csr_irq_o(csr_irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic csr_write(logic [4:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic csr_read(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 msi_req", {31'b0, msi_req}, 0);
    check("R1 intx_req", {31'b0, intx_req}, 0);
    check("R1 intx_assert", {31'b0, intx_assert}, 0);
    check("R1 csr_irq", {31'b0, csr_irq}, 0);
    csr_read(5'h04, d); check("R1 src_en", d, 0);
    csr_read(5'h08, d); check("R1 evt_sts", d, 0);
    csr_read(5'h0C, d); check("R1 evt_en", d, 0);
  endtask

  task automatic t_pend();
    logic [31:0] d;
    @(negedge clk); src = 16'hA5C3;
    csr_read(5'h00, d); check("R2 pend read", d, 32'h0000A5C3);
    csr_write(5'h00, 32'hFFFF_FFFF);
    csr_read(5'h00, d); check("R2 pend write ignored", d, 32'h0000A5C3);
    @(negedge clk); src = '0;
    idle(3);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    csr_write(5'h04, 32'h0001_00F0);
    csr_read(5'h04, d); check("R3 src_en rw", d, 32'h0000_00F0);
  endtask

  task automatic t_msi();
    msi_en = 1'b1; intx_dis = 1'b0; idle(2);
    @(negedge clk); src = 16'h0010;
    @(negedge clk); check("R4 msi not yet", {31'b0, msi_req}, 0);
    @(negedge clk); check("R4 msi pulse", {31'b0, msi_req}, 1);
    check("R4 no intx", {31'b0, intx_req}, 0);
    @(negedge clk); check("R4 msi single", {31'b0, msi_req}, 0);
    src = 16'h0011; // bit0 is disabled
    idle(3); check("R3 disabled src no msi", {31'b0, msi_req}, 0);
    check("R3 disabled src no intx", {31'b0, intx_req}, 0);
    src = 16'h0000; idle(3);
    msi_en = 1'b0; idle(2);
  endtask

  task automatic t_legacy();
    @(negedge clk); src = 16'h0020;
    @(negedge clk); check("R5 req not yet", {31'b0, intx_req}, 0);
    @(negedge clk); check("R5 req", {31'b0, intx_req}, 1);
    check("R5 assert", {31'b0, intx_assert}, 1);
    idle(3); check("R5 hold", {30'b0, intx_req, intx_assert}, 2'b11);
    ack = 1'b1;
    @(negedge clk); ack = 1'b0; check("R5 drop on ack", {31'b0, intx_req}, 0);
    idle(2); check("R5 no repeat", {31'b0, intx_req}, 0);
    src = 16'h0000;
    @(negedge clk);
    @(negedge clk); check("R6 deassert req", {30'b0, intx_req, intx_assert}, 2'b10);
    ack = 1'b1;
    @(negedge clk); ack = 1'b0; check("R6 drop on ack", {31'b0, intx_req}, 0);
  endtask

  task automatic t_queue();
    @(negedge clk); src = 16'h0040;
    idle(2); check("R7 assert req", {30'b0, intx_req, intx_assert}, 2'b11);
    src = 16'h0000; idle(3);
    check("R7 waits for ack", {30'b0, intx_req, intx_assert}, 2'b11);
    ack = 1'b1;
    @(negedge clk); ack = 1'b0; check("R7 idle after ack", {31'b0, intx_req}, 0);
    @(negedge clk); check("R7 queued deassert", {30'b0, intx_req, intx_assert}, 2'b10);
    ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic t_disable();
    intx_dis = 1'b1; msi_en = 1'b0; idle(1);
    src = 16'h0080; idle(5);
    check("R8 no intx", {31'b0, intx_req}, 0);
    check("R8 no msi", {31'b0, msi_req}, 0);
    src = 16'h0000; idle(3); intx_dis = 1'b0; idle(2);
  endtask

  task automatic t_events();
    logic [31:0] d;
    @(negedge clk); evt = 4'b0100;
    @(negedge clk); evt = 4'b0000;
    csr_read(5'h08, d); check("R9 status set", d, 32'h4);
    check("R10 irq masked", {31'b0, csr_irq}, 0);
    csr_write(5'h0C, 32'h0000_0004);
    check("R10 irq on", {31'b0, csr_irq}, 1);
    csr_write(5'h08, 32'h0000_0004);
    check("R10 irq off after clear", {31'b0, csr_irq}, 0);
    csr_read(5'h08, d); check("R9 w1c", d, 32'h0);
    @(negedge clk); evt = 4'b0010; addr = 5'h08; wdata = 32'h2; wr = 1'b1;
    @(negedge clk); evt = 4'b0000; wr = 1'b0;
    csr_read(5'h08, d); check("R9 set wins", d, 32'h2);
    csr_write(5'h08, 32'h2);
  endtask

  task automatic t_undef();
    logic [31:0] d;
    csr_write(5'h14, 32'hFFFF_FFFF);
    csr_write(5'h1C, 32'hFFFF_FFFF);
    csr_read(5'h04, d); check("R11 src_en unchanged", d, 32'h0000_00F0);
    csr_read(5'h0C, d); check("R11 evt_en unchanged", d, 32'h4);
    csr_read(5'h14, d); check("R11 undef reads zero", d, 32'h0);
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_pend();
    t_enable();
    t_msi();
    t_legacy();
    t_queue();
    t_disable();
    t_events();
    t_undef();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule